// File: doc/BRIEF.md
# Hash Engine Command Sequencer

This block is the control state machine of a sponge-style hash and MAC engine. Software, or a hardware application port, issues one-hot commands: begin a job, close the message, run one extra permutation while squeezing, finish the job, and acknowledge an error. The sequencer walks the engine through its phases: idle, absorbing message data, padding and final absorption, squeeze-ready, a software-requested permutation, waiting for error acknowledgement, and a multi-cycle flush. It drives single-cycle strobes toward the datapath, two status bits, an error code and two interrupts that are captured in a sticky register which software clears by writing ones.

The permutation core and the padding datapath are outside this block. They are represented by two completion inputs: one that reports that padding and final absorption are finished, and one that reports that a requested permutation is finished. A small configuration register is held inside the block. It can be written only while the engine is idle, and finishing a job leaves it unchanged.

Top module: `hseq_ctrl`

## Requirements
- R1: Out of reset the status reads idle=1 and squeeze=0, and the interrupt state, error code and configuration are all zero. A configuration write (cfg_we_i) updates cfg_o on the next edge only while idle_o is 1. At any other time cfg_wr_en_o stays 0 and cfg_o keeps its value.
- R2: msg_accept_o follows msg_valid_i only in the absorb phase, which is entered after a Start has been accepted. In every other phase, including before Start, message beats are discarded and msg_accept_o stays 0.
- R3: cmd_i is one-hot with bit 0 = Start, bit 1 = Process, bit 2 = Run, bit 3 = Done and bit 4 = error-processed. A Start in idle pulses absorb_start_o in that cycle, and idle_o falls on the next edge. start_hw_i, sampled with Start, marks the job as coming from a hardware port.
- R4: A Process during absorb pulses pad_start_o. When absorb_done_i is later seen, done_pulse_o is high in that cycle and squeeze_o rises on the next edge.
- R5: A Run while squeeze_o is 1 pulses perm_run_o once. squeeze_o is 0 from the next edge until perm_done_i is seen, and then rises on the following edge. No done pulse is produced for a Run.
- R6: A Done while squeeze_o is 1 asserts state_clr_o in that cycle and returns to idle on the next edge. cfg_o is unchanged.
- R7: err_i, outside the error-wait and flush phases, takes priority over any command in the same cycle. It pulses err_pulse_o, latches err_code_i into err_code_o and enters error-wait, where idle_o and squeeze_o are both 0.
- R8: An error-processed command in error-wait starts a flush. state_clr_o is high for FLUSH_CYCLES cycles, then idle_o rises. In the last flush cycle done_pulse_o fires only if the failed job was started with start_hw_i=0, so the done interrupt bit is set on the same edge on which idle_o rises.
- R9: In the idle, absorb, pad, squeeze and run phases, a nonzero command that is not legal there (including one with more than one bit set) is ignored. It pulses err_pulse_o and sets err_code_o to 0x02. In error-wait and flush, such commands are ignored without any error pulse or change to the code.
- R10: intr_state_o bit 0 (done) and bit 1 (error) are set by done_pulse_o and err_pulse_o. They hold until a 1 is written to the same bit of intr_clr_i. A set in the same cycle as a clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_i | input | 5 | One-hot command: Start, Process, Run, Done, error-processed |
| start_hw_i | input | 1 | Start originates from a hardware application port |
| msg_valid_i | input | 1 | Message beat offered |
| msg_accept_o | output | 1 | Message beat absorbed |
| absorb_done_i | input | 1 | Padding and final absorption finished |
| perm_done_i | input | 1 | Requested permutation finished |
| err_i | input | 1 | Datapath error |
| err_code_i | input | ERR_W | Code accompanying err_i |
| cfg_we_i | input | 1 | Configuration write request |
| cfg_wdata_i | input | CFG_W | Configuration write data |
| cfg_o | output | CFG_W | Current configuration |
| cfg_wr_en_o | output | 1 | Configuration write accepted |
| intr_clr_i | input | 2 | Write-one-to-clear of interrupt state |
| intr_state_o | output | 2 | Sticky interrupt state {error, done} |
| done_pulse_o | output | 1 | Done interrupt event |
| err_pulse_o | output | 1 | Error interrupt event |
| err_code_o | output | ERR_W | Latched error code |
| idle_o | output | 1 | Engine idle status |
| squeeze_o | output | 1 | State readable (squeeze ready) |
| absorb_start_o | output | 1 | Strobe: begin absorbing |
| pad_start_o | output | 1 | Strobe: apply padding and finish absorption |
| perm_run_o | output | 1 | Strobe: run one permutation |
| state_clr_o | output | 1 | Strobe: clear datapath state |

## Verification
The assertions check on every cycle that the configuration cannot move while the engine is busy, that idle and squeeze are never both set, and that each strobe is followed by the phase it implies: squeeze drops after a Run, idle follows a Done, and the error code follows err_i. They also check that interrupt events always leave their sticky bit set. Whether a done pulse is withheld for a hardware-originated job, the exact length of the flush, the silent handling of commands during error recovery, and the error code for an illegal command are shown only by the bench's ordered scenarios.

// File: rtl/hseq_pkg.sv
package hseq_pkg;

  localparam int CMD_W     = 5;
  localparam int C_START   = 0;
  localparam int C_PROCESS = 1;
  localparam int C_RUN     = 2;
  localparam int C_DONE    = 3;
  localparam int C_ERRPROC = 4;

  localparam int IRQ_N     = 2;
  localparam int IRQ_DONE  = 0;
  localparam int IRQ_ERR   = 1;

  localparam logic [7:0] BAD_CMD_CODE = 8'h02;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_ABSORB  = 3'd1,
    ST_PAD     = 3'd2,
    ST_SQUEEZE = 3'd3,
    ST_RUN     = 3'd4,
    ST_ERRWAIT = 3'd5,
    ST_FLUSH   = 3'd6
  } st_e;

  // Commands that may be acted on in a given phase.
  function automatic logic [CMD_W-1:0] legal_cmds(st_e s);
    logic [CMD_W-1:0] m;
    m = '0;
    case (s)
      ST_IDLE:    m[C_START]   = 1'b1;
      ST_ABSORB:  m[C_PROCESS] = 1'b1;
      ST_SQUEEZE: begin
        m[C_RUN]  = 1'b1;
        m[C_DONE] = 1'b1;
      end
      ST_ERRWAIT: m[C_ERRPROC] = 1'b1;
      default:    m = '0;
    endcase
    return m;
  endfunction

  function automatic logic cmd_ok(st_e s, logic [CMD_W-1:0] c);
    return ($countones(c) == 1) && ((c & legal_cmds(s)) != '0);
  endfunction

  // Phases in which stray commands are dropped silently.
  function automatic logic recovering(st_e s);
    return (s == ST_ERRWAIT) || (s == ST_FLUSH);
  endfunction

endpackage

// File: rtl/hseq_cmd_decode.sv
module hseq_cmd_decode
  import hseq_pkg::*;
(
  input  st_e              st_i,
  input  logic [CMD_W-1:0] cmd_i,
  output logic [CMD_W-1:0] go_o,
  output logic             bad_o
);

  logic ok;

  always_comb begin
    ok    = cmd_ok(st_i, cmd_i);
    go_o  = ok ? cmd_i : '0;
    bad_o = (cmd_i != '0) && !ok && !recovering(st_i);
  end

endmodule

// File: rtl/hseq_irq.sv
module hseq_irq #(
  parameter int N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] state_o
);

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q <= 1'b0;
      else if (set_i[i]) q <= 1'b1;
      else if (clr_i[i]) q <= 1'b0;
    end
    assign state_o[i] = q;
  end

endmodule

// File: rtl/hseq_fsm.sv
module hseq_fsm
  import hseq_pkg::*;
#(
  parameter int ERR_W        = 8,
  parameter int FLUSH_CYCLES = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CMD_W-1:0] go_i,
  input  logic             bad_i,
  input  logic             start_hw_i,
  input  logic             absorb_done_i,
  input  logic             perm_done_i,
  input  logic             err_i,
  input  logic [ERR_W-1:0] err_code_i,
  output st_e              st_o,
  output logic             err_take_o,
  output logic             flush_last_o,
  output logic             absorb_start_o,
  output logic             pad_start_o,
  output logic             perm_run_o,
  output logic             state_clr_o,
  output logic             done_pulse_o,
  output logic             err_pulse_o,
  output logic [ERR_W-1:0] err_code_o
);

  localparam int CNT_W = $clog2(FLUSH_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FLUSH_CYCLES - 1);

  st_e              st_q, st_d;
  logic [CNT_W-1:0] cnt_q;
  logic             job_sw_q;
  logic [ERR_W-1:0] code_q;

  assign st_o         = st_q;
  assign err_take_o   = err_i && !recovering(st_q);
  assign flush_last_o = (st_q == ST_FLUSH) && (cnt_q == CNT_LAST);

  always_comb begin
    st_d = st_q;
    if (err_take_o) begin
      st_d = ST_ERRWAIT;
    end else begin
      case (st_q)
        ST_IDLE:    if (go_i[C_START])   st_d = ST_ABSORB;
        ST_ABSORB:  if (go_i[C_PROCESS]) st_d = ST_PAD;
        ST_PAD:     if (absorb_done_i)   st_d = ST_SQUEEZE;
        ST_SQUEEZE: begin
          if (go_i[C_RUN])       st_d = ST_RUN;
          else if (go_i[C_DONE]) st_d = ST_IDLE;
        end
        ST_RUN:     if (perm_done_i)     st_d = ST_SQUEEZE;
        ST_ERRWAIT: if (go_i[C_ERRPROC]) st_d = ST_FLUSH;
        ST_FLUSH:   if (flush_last_o)    st_d = ST_IDLE;
        default:    st_d = ST_IDLE;
      endcase
    end
  end

  always_comb begin
    absorb_start_o = !err_take_o && (st_q == ST_IDLE)   && go_i[C_START];
    pad_start_o    = !err_take_o && (st_q == ST_ABSORB) && go_i[C_PROCESS];
    perm_run_o     = !err_take_o && (st_q == ST_SQUEEZE) && go_i[C_RUN];
    state_clr_o    = (st_q == ST_FLUSH) ||
                     (!err_take_o && (st_q == ST_SQUEEZE) && go_i[C_DONE]);
    done_pulse_o   = !err_take_o &&
                     (((st_q == ST_PAD) && absorb_done_i) || (flush_last_o && job_sw_q));
    err_pulse_o    = err_take_o || bad_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      cnt_q    <= '0;
      job_sw_q <= 1'b0;
      code_q   <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= (st_q == ST_FLUSH) ? cnt_q + CNT_W'(1) : '0;
      if (absorb_start_o)         job_sw_q <= !start_hw_i;
      else if (st_d == ST_IDLE)   job_sw_q <= 1'b0;
      if (err_take_o)             code_q <= err_code_i;
      else if (bad_i)             code_q <= ERR_W'(BAD_CMD_CODE);
    end
  end

  assign err_code_o = code_q;

endmodule

// File: rtl/hseq_ctrl.sv
module hseq_ctrl
  import hseq_pkg::*;
#(
  parameter int CFG_W        = 8,
  parameter int ERR_W        = 8,
  parameter int FLUSH_CYCLES = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [4:0]       cmd_i,
  input  logic             start_hw_i,
  input  logic             msg_valid_i,
  output logic             msg_accept_o,
  input  logic             absorb_done_i,
  input  logic             perm_done_i,
  input  logic             err_i,
  input  logic [ERR_W-1:0] err_code_i,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  output logic [CFG_W-1:0] cfg_o,
  output logic             cfg_wr_en_o,
  input  logic [1:0]       intr_clr_i,
  output logic [1:0]       intr_state_o,
  output logic             done_pulse_o,
  output logic             err_pulse_o,
  output logic [ERR_W-1:0] err_code_o,
  output logic             idle_o,
  output logic             squeeze_o,
  output logic             absorb_start_o,
  output logic             pad_start_o,
  output logic             perm_run_o,
  output logic             state_clr_o
);

  st_e              st;
  logic [CMD_W-1:0] go;
  logic             bad_cmd;
  logic             err_take;
  logic             flush_last;
  logic [CFG_W-1:0] cfg_q;
  logic [IRQ_N-1:0] irq_set;

  hseq_cmd_decode u_dec (
    .st_i  (st),
    .cmd_i (cmd_i),
    .go_o  (go),
    .bad_o (bad_cmd)
  );

  hseq_fsm #(
    .ERR_W        (ERR_W),
    .FLUSH_CYCLES (FLUSH_CYCLES)
  ) u_fsm (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .go_i           (go),
    .bad_i          (bad_cmd),
    .start_hw_i     (start_hw_i),
    .absorb_done_i  (absorb_done_i),
    .perm_done_i    (perm_done_i),
    .err_i          (err_i),
    .err_code_i     (err_code_i),
    .st_o           (st),
    .err_take_o     (err_take),
    .flush_last_o   (flush_last),
    .absorb_start_o (absorb_start_o),
    .pad_start_o    (pad_start_o),
    .perm_run_o     (perm_run_o),
    .state_clr_o    (state_clr_o),
    .done_pulse_o   (done_pulse_o),
    .err_pulse_o    (err_pulse_o),
    .err_code_o     (err_code_o)
  );

  assign idle_o       = (st == ST_IDLE);
  assign squeeze_o    = (st == ST_SQUEEZE);
  assign msg_accept_o = msg_valid_i && (st == ST_ABSORB);
  assign cfg_wr_en_o  = cfg_we_i && idle_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cfg_q <= '0;
    else if (cfg_wr_en_o) cfg_q <= cfg_wdata_i;
  end
  assign cfg_o = cfg_q;

  always_comb begin
    irq_set           = '0;
    irq_set[IRQ_DONE] = done_pulse_o;
    irq_set[IRQ_ERR]  = err_pulse_o;
  end

  hseq_irq #(.N(IRQ_N)) u_irq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (irq_set),
    .clr_i   (intr_clr_i),
    .state_o (intr_state_o)
  );

endmodule

// File: rtl/hseq_ctrl_chk.sv
module hseq_ctrl_chk #(
  parameter int CFG_W = 8,
  parameter int ERR_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cfg_we_i,
  input logic [CFG_W-1:0] cfg_o,
  input logic             msg_accept_o,
  input logic             err_i,
  input logic [ERR_W-1:0] err_code_i,
  input logic [ERR_W-1:0] err_code_o,
  input logic             err_take,
  input logic [1:0]       intr_state_o,
  input logic             done_pulse_o,
  input logic             err_pulse_o,
  input logic             idle_o,
  input logic             squeeze_o,
  input logic             absorb_start_o,
  input logic             perm_run_o,
  input logic             state_clr_o
);

  // R1
  cfg_frozen_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && !idle_o) |=> $stable(cfg_o));

  // R1
  status_exclusive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({idle_o, squeeze_o}));

  // R2
  accept_in_absorb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_accept_o |-> (!idle_o && !squeeze_o));

  // R3
  start_leaves_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    absorb_start_o |=> (!idle_o && !squeeze_o));

  // R4
  done_opens_squeeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_pulse_o && !state_clr_o) |=> squeeze_o);

  // R5
  run_drops_squeeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    perm_run_o |=> (!squeeze_o && !done_pulse_o));

  // R6
  done_cmd_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_clr_o && squeeze_o) |=> (idle_o && $stable(cfg_o)));

  // R7
  err_code_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_i && err_take) |=> (err_code_o == $past(err_code_i) && !idle_o && !squeeze_o));

  // R10
  done_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_pulse_o |=> intr_state_o[0]);

  // R10
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_pulse_o |=> intr_state_o[1]);

endmodule

bind hseq_ctrl hseq_ctrl_chk #(.CFG_W(CFG_W), .ERR_W(ERR_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .cfg_we_i       (cfg_we_i),
  .cfg_o          (cfg_o),
  .msg_accept_o   (msg_accept_o),
  .err_i          (err_i),
  .err_code_i     (err_code_i),
  .err_code_o     (err_code_o),
  .err_take       (err_take),
  .intr_state_o   (intr_state_o),
  .done_pulse_o   (done_pulse_o),
  .err_pulse_o    (err_pulse_o),
  .idle_o         (idle_o),
  .squeeze_o      (squeeze_o),
  .absorb_start_o (absorb_start_o),
  .perm_run_o     (perm_run_o),
  .state_clr_o    (state_clr_o)
);

// File: tb/hseq_ctrl_tb.sv
module hseq_ctrl_tb;

  localparam int NV = 27;

  typedef struct packed {
    logic [4:0] cmd;
    logic       hw;
    logic       mv;
    logic       ad;
    logic       pd;
    logic       er;
    logic [3:0] strb;   // {absorb_start, pad_start, perm_run, state_clr}
    logic       dn;
    logic       ep;
    logic       acc;
    logic       nidle;
    logic       nsq;
    logic [3:0] req;
  } vec_t;

  // Flush length is the default of four cycles.
  localparam vec_t VECS [NV] = '{
    '{5'b00000,1'b0,1'b1,1'b0,1'b0,1'b0,4'b0000,1'b0,1'b0,1'b0,1'b1,1'b0,4'd2}, // R2 before Start
    '{5'b00001,1'b0,1'b0,1'b0,1'b0,1'b0,4'b1000,1'b0,1'b0,1'b0,1'b0,1'b0,4'd3}, // R3 sw start
    '{5'b00000,1'b0,1'b1,1'b0,1'b0,1'b0,4'b0000,1'b0,1'b0,1'b1,1'b0,1'b0,4'd2}, // R2 absorb
    '{5'b00010,1'b0,1'b0,1'b0,1'b0,1'b0,4'b0100,1'b0,1'b0,1'b0,1'b0,1'b0,4'd4}, // R4 process
    '{5'b00000,1'b0,1'b1,1'b0,1'b0,1'b0,4'b0000,1'b0,1'b0,1'b0,1'b0,1'b0,4'd2}, // R2 pad drops beat
    '{5'b00000,1'b0,1'b0,1'b1,1'b0,1'b0,4'b0000,1'b1,1'b0,1'b0,1'b0,1'b1,4'd4}, // R4 absorb done
    '{5'b00100,1'b0,1'b0,1'b0,1'b0,1'b0,4'b0010,1'b0,1'b0,1'b0,1'b0,1'b0,4'd5}, // R5 run
    '{5'b00000,1'b0,1'b0,1'b0,1'b0,1'b0,4'b0000,1'b0,1'b0,1'b0,1'b0,1'b0,4'd5}, // R5 busy
    '{5'b00000,1'b0,1'b0,1'b0,1'b1,1'b0,4'b0000,1'b0,1'b0,1'b0,1'b0,1'b1,4'd5}, // R5 perm done
    '{5'b00010,1'b0,1'b0,1'b0,1'b0,1'b0,4'b0000,1'b0,1'b1,1'b0,1'b0,1'b1,4'd9}, // R9 bad in squeeze
    '{5'b01000,1'b0,1'b0,1'b0,1'b0,1'b0,4'b0001,1'b0,1'b0,1'b0,1'b1,1'b0,4'd6}, // R6 done cmd
    '{5'b00001,1'b1,1'b0,1'b0,1'b0,1'b0,4'b1000,1'b0,1'b0,1'b0,1'b0,1'b0,4'd3}, // R3 hw start
    '{5'b00010,1'b0,1'b0,1'b0,1'b0,1'b1,4'b0000,1'b0,1'b1,1'b0,1'b0,1'b0,4'd7}, // R7 err beats cmd
    '{5'b10000,1'b0,1'b0,1'b0,1'b0,1'b0,4'b0000,1'b0,1'b0,1'b0,1'b0,1'b0,4'd8}, // R8 ack
    '{5'b00000,1'b0,1'b0,1'b0,1'b0,1'b0,4'b0001,1'b0,1'b0,1'b0,1'b0,1'b0,4'd8},
    '{5'b00000,1'b0,1'b0,1'b0,1'b0,1'b0,4'b0001,1'b0,1'b0,1'b0,1'b0,1'b0,4'd8},
    '{5'b00000,1'b0,1'b0,1'b0,1'b0,1'b0,4'b0001,1'b0,1'b0,1'b0,1'b0,1'b0,4'd8},
    '{5'b00000,1'b0,1'b0,1'b0,1'b0,1'b0,4'b0001,1'b0,1'b0,1'b0,1'b1,1'b0,4'd8}, // R8 hw: no done
    '{5'b00001,1'b0,1'b0,1'b0,1'b0,1'b0,4'b1000,1'b0,1'b0,1'b0,1'b0,1'b0,4'd3},
    '{5'b00000,1'b0,1'b0,1'b0,1'b0,1'b1,4'b0000,1'b0,1'b1,1'b0,1'b0,1'b0,4'd7}, // R7
    '{5'b10000,1'b0,1'b0,1'b0,1'b0,1'b0,4'b0000,1'b0,1'b0,1'b0,1'b0,1'b0,4'd8},
    '{5'b00000,1'b0,1'b0,1'b0,1'b0,1'b0,4'b0001,1'b0,1'b0,1'b0,1'b0,1'b0,4'd8},
    '{5'b00000,1'b0,1'b0,1'b0,1'b0,1'b0,4'b0001,1'b0,1'b0,1'b0,1'b0,1'b0,4'd8},
    '{5'b00000,1'b0,1'b0,1'b0,1'b0,1'b0,4'b0001,1'b0,1'b0,1'b0,1'b0,1'b0,4'd8},
    '{5'b00000,1'b0,1'b0,1'b0,1'b0,1'b0,4'b0001,1'b1,1'b0,1'b0,1'b1,1'b0,4'd8}, // R8 sw: done
    '{5'b00011,1'b0,1'b0,1'b0,1'b0,1'b0,4'b0000,1'b0,1'b1,1'b0,1'b1,1'b0,4'd9}, // R9 two bits
    '{5'b01000,1'b0,1'b0,1'b0,1'b0,1'b0,4'b0000,1'b0,1'b1,1'b0,1'b1,1'b0,4'd9}  // R9 done in idle
  };

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [4:0] cmd_i = '0;
  logic       start_hw_i = 1'b0, msg_valid_i = 1'b0, absorb_done_i = 1'b0;
  logic       perm_done_i = 1'b0, err_i = 1'b0, cfg_we_i = 1'b0;
  logic [7:0] err_code_i = '0, cfg_wdata_i = '0;
  logic [1:0] intr_clr_i = '0;
  logic [7:0] cfg_o, err_code_o;
  logic [1:0] intr_state_o;
  logic msg_accept_o, cfg_wr_en_o, done_pulse_o, err_pulse_o, idle_o, squeeze_o;
  logic absorb_start_o, pad_start_o, perm_run_o, state_clr_o;

  int n_run = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  hseq_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_i(cmd_i), .start_hw_i(start_hw_i),
    .msg_valid_i(msg_valid_i), .msg_accept_o(msg_accept_o),
    .absorb_done_i(absorb_done_i), .perm_done_i(perm_done_i),
    .err_i(err_i), .err_code_i(err_code_i), .cfg_we_i(cfg_we_i),
    .cfg_wdata_i(cfg_wdata_i), .cfg_o(cfg_o), .cfg_wr_en_o(cfg_wr_en_o),
    .intr_clr_i(intr_clr_i), .intr_state_o(intr_state_o),
    .done_pulse_o(done_pulse_o), .err_pulse_o(err_pulse_o),
    .err_code_o(err_code_o), .idle_o(idle_o), .squeeze_o(squeeze_o),
    .absorb_start_o(absorb_start_o), .pad_start_o(pad_start_o),
    .perm_run_o(perm_run_o), .state_clr_o(state_clr_o)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic quiet();
    cmd_i = '0; start_hw_i = 0; msg_valid_i = 0; absorb_done_i = 0;
    perm_done_i = 0; err_i = 0; cfg_we_i = 0; intr_clr_i = '0;
  endtask

  task automatic edge_after();
    @(posedge clk); #1;
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_ni = 1'b1;
    #1;
    // R1 reset state
    check("R1", "reset status", {30'd0, idle_o, squeeze_o}, 32'h2);
    check("R1", "reset intr/code/cfg", {14'd0, intr_state_o, err_code_o, cfg_o}, 32'h0);

    // R1 write in idle
    @(negedge clk); cfg_we_i = 1; cfg_wdata_i = 8'hA5; #1;
    check("R1", "wr_en idle", {31'd0, cfg_wr_en_o}, 32'h1);
    edge_after();
    check("R1", "cfg idle write", {24'd0, cfg_o}, 32'hA5);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      quiet();
      cmd_i = VECS[i].cmd; start_hw_i = VECS[i].hw; msg_valid_i = VECS[i].mv;
      absorb_done_i = VECS[i].ad; perm_done_i = VECS[i].pd; err_i = VECS[i].er;
      err_code_i = 8'h33;
      #1;
      check($sformatf("R%0d", VECS[i].req), $sformatf("row %0d outputs", i),
            {27'd0, absorb_start_o, pad_start_o, perm_run_o, state_clr_o, 1'b0},
            {27'd0, VECS[i].strb, 1'b0});
      check($sformatf("R%0d", VECS[i].req), $sformatf("row %0d pulses", i),
            {29'd0, done_pulse_o, err_pulse_o, msg_accept_o},
            {29'd0, VECS[i].dn, VECS[i].ep, VECS[i].acc});
      edge_after();
      check($sformatf("R%0d", VECS[i].req), $sformatf("row %0d status", i),
            {30'd0, idle_o, squeeze_o}, {30'd0, VECS[i].nidle, VECS[i].nsq});
    end
    @(negedge clk); quiet();

    // R6 configuration survived the Done command
    check("R6", "cfg after done", {24'd0, cfg_o}, 32'hA5);
    // R9 code for illegal command
    check("R9", "bad cmd code", {24'd0, err_code_o}, 32'h02);
    // R10 sticky bits and W1C
    check("R10", "intr sticky", {30'd0, intr_state_o}, 32'h3);
    intr_clr_i = 2'b01; edge_after();
    check("R10", "clear done bit", {30'd0, intr_state_o}, 32'h2);
    @(negedge clk); intr_clr_i = 2'b10; edge_after();
    check("R10", "clear err bit", {30'd0, intr_state_o}, 32'h0);

    // R1 write ignored while absorbing
    @(negedge clk); quiet(); cmd_i = 5'b00001; edge_after();
    @(negedge clk); quiet(); cfg_we_i = 1; cfg_wdata_i = 8'h3C; #1;
    check("R1", "wr_en busy", {31'd0, cfg_wr_en_o}, 32'h0);
    edge_after();
    check("R1", "cfg busy write", {24'd0, cfg_o}, 32'hA5);

    // R7 error code latch
    @(negedge clk); quiet(); err_i = 1; err_code_i = 8'h5A; edge_after();
    check("R7", "err code", {24'd0, err_code_o}, 32'h5A);
    check("R7", "status in err wait", {30'd0, idle_o, squeeze_o}, 32'h0);

    // R9 silent drop during error wait
    @(negedge clk); quiet(); cmd_i = 5'b00001; #1;
    check("R9", "no err pulse in wait", {31'd0, err_pulse_o}, 32'h0);
    edge_after();
    check("R9", "code kept in wait", {24'd0, err_code_o}, 32'h5A);
    check("R9", "still waiting", {30'd0, idle_o, squeeze_o}, 32'h0);

    // R8 flush length and done re-signalled for software job
    @(negedge clk); quiet(); intr_clr_i = 2'b11; cmd_i = 5'b10000; edge_after();
    @(negedge clk); quiet();
    repeat (3) edge_after();
    check("R8", "idle before flush end", {31'd0, idle_o}, 32'h0);
    edge_after();
    check("R8", "idle after flush", {31'd0, idle_o}, 32'h1);
    check("R8", "done bit with idle", {31'd0, intr_state_o[0]}, 32'h1);

    // R10 set wins over clear
    @(negedge clk); quiet(); cmd_i = 5'b00110; intr_clr_i = 2'b10; edge_after();
    check("R10", "set beats clear", {31'd0, intr_state_o[1]}, 32'h1);
    @(negedge clk); quiet();

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule